// File: doc/BRIEF.md
# Comparator Edge Interrupt Controller

This block watches the single-bit digital result of an analog comparator and latches an interrupt flag when a chosen kind of transition occurs: any change, only high-to-low, or only low-to-high. The comparator bit comes from another clock domain, so it passes through a synchronizer first. Edges are then found by comparing the synchronized value with a registered copy of it. The flag stays set until software clears it by writing 1, or until the interrupt is acknowledged. The interrupt line is the flag gated by an enable bit.

The block also produces the select code for the comparator's negative-input multiplexer. The multiplexed channels are used only when the mux-enable bit is set and the shared converter is off. In that case the 3-bit channel field picks one of eight converter channels. In every other case a dedicated pin is selected.

Software drives all configuration through one write strobe. A single write updates the mode, interrupt enable, mux enable, converter enable and channel, and can also clear the flag. The mode is not masked while it changes. If the enable is left set during a mode change, the new mode is applied at once to the current pair of samples.

Top module: `cmp_event_irq_ctrl`

## Requirements
- R1: After reset the mode is 00, the enable, mux-enable, converter-enable, channel and flag are 0, `neg_sel` is 8 and `irq` is 0. A comparator input held high through reset and its release produces no event.
- R2: With mode code 00, every change of the synchronized comparator value, in either direction, sets the flag.
- R3: With mode code 10, only a 1-to-0 change sets the flag. A 0-to-1 change does not set it.
- R4: With mode code 11, only a 0-to-1 change sets the flag. A 1-to-0 change does not set it.
- R5: Mode code 01 is reserved. In this mode no change of the comparator sets the flag.
- R6: The flag is sticky. It is cleared by a write with `wr_flag_clr`=1. If an event occurs in the same cycle as the clear, the event wins.
- R7: A one-cycle `irq_ack` pulse clears the flag, unless an event occurs in the same cycle.
- R8: `irq` equals flag AND enable. The flag can be set while the enable is 0, and it appears on `irq` as soon as the enable is written to 1.
- R9: When mux-enable is 1 and converter-enable is 0, `neg_sel` equals the 3-bit channel value (0 to 7, binary).
- R10: When mux-enable is 0 or converter-enable is 1, `neg_sel` is 8 (dedicated pin) and the channel field has no effect.
- R11: A change on `cmp_in` that is set up before rising edge k sets the flag at edge k+2. `irq` therefore rises in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe; loads all configuration fields below |
| wr_mode | input | 2 | Event mode: 00 toggle, 01 reserved, 10 falling, 11 rising |
| wr_irq_en | input | 1 | Interrupt enable |
| wr_mux_en | input | 1 | Negative-input multiplexer enable |
| wr_conv_en | input | 1 | Shared converter enable (blocks the multiplexer) |
| wr_chan | input | 3 | Converter channel for the negative input |
| wr_flag_clr | input | 1 | With wr_en, 1 clears the interrupt flag |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| cmp_in | input | 1 | Asynchronous comparator output |
| irq | output | 1 | Interrupt request |
| neg_sel | output | 4 | Negative-input select: 0 to 7 channel, 8 dedicated pin |

## Verification
The assertions assume that `irq_ack` and the flag-clear write are the only ways to clear the flag. They also assume that `cmp_in` changes slowly enough for the synchronizer to resolve it. The stimulus changes `cmp_in` only on falling clock edges and holds each level for several cycles. Mode changes are made with nothing pending in the edge pipeline, so each event is attributed to one mode only. A behavioural model keeps the history of sampled input values and is compared with both outputs on every clock.

// File: rtl/cmpirq_pkg.sv
package cmpirq_pkg;
    typedef enum logic [1:0] {
        EVT_TOGGLE = 2'b00,
        EVT_RSVD   = 2'b01,
        EVT_FALL   = 2'b10,
        EVT_RISE   = 2'b11
    } evt_mode_e;

    function automatic logic evt_match(evt_mode_e mode, logic rise, logic fall);
        case (mode)
            EVT_TOGGLE: return rise | fall;
            EVT_FALL:   return fall;
            EVT_RISE:   return rise;
            default:    return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/cmpirq_sync.sv
module cmpirq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = d;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/cmpirq_edge.sv
module cmpirq_edge
    import cmpirq_pkg::*;
#(
    parameter int ARM_LEN = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      smp,
    input  evt_mode_e mode,
    output logic      prev,
    output logic      evt
);
    typedef struct packed {
        logic               prev;
        logic [ARM_LEN-1:0] arm;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic rise, fall;

    always_comb begin
        st_d      = st_q;
        st_d.prev = smp;
        st_d.arm  = {st_q.arm[ARM_LEN-2:0], 1'b1};
        rise      = smp & ~st_q.prev;
        fall      = ~smp & st_q.prev;
        evt       = st_q.arm[ARM_LEN-1] & evt_match(mode, rise, fall);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prev = st_q.prev;
endmodule

// File: rtl/cmpirq_negsel.sv
module cmpirq_negsel #(
    parameter int CHAN_W = 3,
    localparam int SEL_W = CHAN_W + 1
) (
    input  logic              mux_en,
    input  logic              conv_en,
    input  logic [CHAN_W-1:0] chan,
    output logic [SEL_W-1:0]  sel
);
    localparam logic [SEL_W-1:0] PIN_CODE = {1'b1, {CHAN_W{1'b0}}};

    always_comb begin
        if (mux_en && !conv_en) sel = {1'b0, chan};
        else                    sel = PIN_CODE;
    end
endmodule

// File: rtl/cmp_event_irq_ctrl.sv
module cmp_event_irq_ctrl
    import cmpirq_pkg::*;
#(
    parameter int CHAN_W      = 3,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = CHAN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_mode,
    input  logic              wr_irq_en,
    input  logic              wr_mux_en,
    input  logic              wr_conv_en,
    input  logic [CHAN_W-1:0] wr_chan,
    input  logic              wr_flag_clr,
    input  logic              irq_ack,
    input  logic              cmp_in,
    output logic              irq,
    output logic [SEL_W-1:0]  neg_sel
);
    localparam int ARM_LEN = SYNC_STAGES + 1;

    typedef struct packed {
        evt_mode_e         mode;
        logic              irq_en;
        logic              mux_en;
        logic              conv_en;
        logic [CHAN_W-1:0] chan;
        logic              flag;
    } ctl_st_t;

    ctl_st_t st_d, st_q;
    logic    smp, prev, evt, clr;

    cmpirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(cmp_in), .q(smp)
    );

    cmpirq_edge #(.ARM_LEN(ARM_LEN)) u_edge (
        .clk(clk), .rst_n(rst_n), .smp(smp), .mode(st_q.mode),
        .prev(prev), .evt(evt)
    );

    cmpirq_negsel #(.CHAN_W(CHAN_W)) u_negsel (
        .mux_en(st_q.mux_en), .conv_en(st_q.conv_en), .chan(st_q.chan),
        .sel(neg_sel)
    );

    always_comb begin
        st_d = st_q;
        clr  = wr_en & wr_flag_clr;
        if (wr_en) begin
            st_d.mode    = evt_mode_e'(wr_mode);
            st_d.irq_en  = wr_irq_en;
            st_d.mux_en  = wr_mux_en;
            st_d.conv_en = wr_conv_en;
            st_d.chan    = wr_chan;
        end
        st_d.flag = evt | (st_q.flag & ~clr & ~irq_ack);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: EVT_TOGGLE, default: '0};
        else        st_q <= st_d;
    end

    assign irq = st_q.flag & st_q.irq_en;
endmodule

// File: rtl/cmpirq_chk.sv
module cmpirq_chk #(
    parameter int CHAN_W = 3,
    localparam int SEL_W = CHAN_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             wr_flag_clr,
    input logic             irq_ack,
    input logic [SEL_W-1:0] neg_sel,
    input logic [1:0]       mode,
    input logic             mux_en,
    input logic             conv_en,
    input logic             flag,
    input logic             evt,
    input logic             smp,
    input logic             prev
);
    localparam logic [SEL_W-1:0] PIN_CODE = {1'b1, {CHAN_W{1'b0}}};

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flag) && !$past(irq_ack) && !$past(wr_en && wr_flag_clr)) |-> flag);

    // R7
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq_ack) && !$past(evt)) |-> !flag);

    // R5
    rsvd_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'b01) |-> !$rose(flag));

    // R4
    rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flag) && $past(mode) == 2'b11) |-> ($past(smp) && !$past(prev)));

    // R3
    fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flag) && $past(mode) == 2'b10) |-> (!$past(smp) && $past(prev)));

    // R10
    pin_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mux_en || conv_en) |-> (neg_sel == PIN_CODE));

    // R9
    chan_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_en && !conv_en) |-> !neg_sel[CHAN_W]);
endmodule

bind cmp_event_irq_ctrl cmpirq_chk #(.CHAN_W(CHAN_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_flag_clr(wr_flag_clr),
    .irq_ack(irq_ack), .neg_sel(neg_sel), .mode(st_q.mode),
    .mux_en(st_q.mux_en), .conv_en(st_q.conv_en), .flag(st_q.flag),
    .evt(evt), .smp(smp), .prev(prev)
);

// File: tb/test_cmp_event_irq_ctrl.sv
`timescale 1ns/1ps
module test_cmp_event_irq_ctrl;
    localparam real PERIOD = 20.0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_mode = 2'b00;
    logic       wr_irq_en = 1'b0;
    logic       wr_mux_en = 1'b0;
    logic       wr_conv_en = 1'b0;
    logic [2:0] wr_chan = 3'd0;
    logic       wr_flag_clr = 1'b0;
    logic       irq_ack = 1'b0;
    logic       cmp_in = 1'b1;
    logic       irq;
    logic [3:0] neg_sel;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    cmp_event_irq_ctrl i_cmp_event_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mode(wr_mode),
        .wr_irq_en(wr_irq_en), .wr_mux_en(wr_mux_en), .wr_conv_en(wr_conv_en),
        .wr_chan(wr_chan), .wr_flag_clr(wr_flag_clr), .irq_ack(irq_ack),
        .cmp_in(cmp_in), .irq(irq), .neg_sel(neg_sel)
    );

    always #(PERIOD/2) clk = ~clk;

    // behavioural reference: history of sampled inputs plus config state
    logic samples[$];
    int   m_n;
    logic [1:0] m_mode;
    logic m_en, m_mux, m_conv, m_flag;
    int   m_chan;

    always @(posedge clk) begin
        if (!rst_n) begin
            samples.delete();
            m_n = 0; m_mode = 2'b00; m_en = 0; m_mux = 0; m_conv = 0;
            m_chan = 0; m_flag = 0;
        end else begin
            logic ev, now_v, old_v;
            m_n++;
            samples.push_back(cmp_in);
            ev = 1'b0;
            if (m_n >= 4) begin
                now_v = samples[m_n-3];
                old_v = samples[m_n-4];
                if (m_mode == 2'b00) ev = (now_v != old_v);
                else if (m_mode == 2'b10) ev = (old_v && !now_v);
                else if (m_mode == 2'b11) ev = (!old_v && now_v);
            end
            if (ev) m_flag = 1'b1;
            else if (irq_ack || (wr_en && wr_flag_clr)) m_flag = 1'b0;
            if (wr_en) begin
                m_mode = wr_mode; m_en = wr_irq_en; m_mux = wr_mux_en;
                m_conv = wr_conv_en; m_chan = int'(wr_chan);
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int exp_sel;
            exp_sel = (m_mux && !m_conv) ? m_chan : 8;
            check(irq == (m_flag && m_en), "R11 irq vs model", int'(irq), int'(m_flag && m_en));
            check(int'(neg_sel) == exp_sel, "R9 neg_sel vs model", int'(neg_sel), exp_sel);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] mode, input logic en, input logic mux,
                      input logic conv, input logic [2:0] ch, input logic clr);
        wr_en = 1; wr_mode = mode; wr_irq_en = en; wr_mux_en = mux;
        wr_conv_en = conv; wr_chan = ch; wr_flag_clr = clr;
        @(negedge clk);
        wr_en = 0; wr_flag_clr = 0;
    endtask

    task automatic set_cmp(input logic v);
        cmp_in = v;
        cyc(5);
    endtask

    initial begin
        #(PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1;
        cyc(6);
        // R1: reset state, input high through reset gives no event
        check(irq == 0, "R1 irq after reset", int'(irq), 0);
        check(neg_sel == 4'd8, "R1 neg_sel after reset", int'(neg_sel), 8);
        wr(2'b00, 1, 0, 0, 3'd0, 0);
        check(irq == 0, "R1 no flag from reset", int'(irq), 0);

        // R2: toggle mode, both directions
        cmp_in = 0;
        cyc(2);
        check(irq == 0, "R11 not yet after two edges", int'(irq), 0);
        cyc(1);
        check(irq == 1, "R11 flag after third edge", int'(irq), 1);
        check(irq == 1, "R2 toggle falling", int'(irq), 1);
        wr(2'b00, 1, 0, 0, 3'd0, 1);
        check(irq == 0, "R6 write-1 clears", int'(irq), 0);
        set_cmp(1);
        check(irq == 1, "R2 toggle rising", int'(irq), 1);

        // R6: sticky
        cyc(10);
        check(irq == 1, "R6 flag sticky", int'(irq), 1);
        wr(2'b00, 1, 0, 0, 3'd0, 0);
        check(irq == 1, "R6 write without clear keeps flag", int'(irq), 1);

        // R7: acknowledge
        irq_ack = 1; cyc(1); irq_ack = 0;
        check(irq == 0, "R7 ack clears", int'(irq), 0);

        // R3: falling mode
        wr(2'b10, 1, 0, 0, 3'd0, 1);
        set_cmp(0);
        check(irq == 1, "R3 falling sets", int'(irq), 1);
        wr(2'b10, 1, 0, 0, 3'd0, 1);
        set_cmp(1);
        check(irq == 0, "R3 rising ignored", int'(irq), 0);

        // R4: rising mode
        wr(2'b11, 1, 0, 0, 3'd0, 1);
        set_cmp(0);
        check(irq == 0, "R4 falling ignored", int'(irq), 0);
        set_cmp(1);
        check(irq == 1, "R4 rising sets", int'(irq), 1);

        // R5: reserved mode
        wr(2'b01, 1, 0, 0, 3'd0, 1);
        set_cmp(0);
        check(irq == 0, "R5 reserved falling", int'(irq), 0);
        set_cmp(1);
        check(irq == 0, "R5 reserved rising", int'(irq), 0);

        // R8: flag set while disabled shows once enabled
        wr(2'b00, 0, 0, 0, 3'd0, 1);
        set_cmp(0);
        check(irq == 0, "R8 masked while disabled", int'(irq), 0);
        wr(2'b00, 1, 0, 0, 3'd0, 0);
        check(irq == 1, "R8 visible after enable", int'(irq), 1);

        // R6: event and clear in the same cycle, event wins
        wr(2'b00, 1, 0, 0, 3'd0, 1);
        cmp_in = 1;
        cyc(2);
        wr(2'b00, 1, 0, 0, 3'd0, 1);
        check(irq == 1, "R6 event beats clear", int'(irq), 1);
        wr(2'b00, 1, 0, 0, 3'd0, 1);

        // R9: multiplexed channels
        for (int c = 0; c < 8; c++) begin
            wr(2'b00, 1, 1, 0, 3'(c), 0);
            check(int'(neg_sel) == c, "R9 channel select", int'(neg_sel), c);
        end

        // R10: dedicated pin cases
        wr(2'b00, 1, 1, 1, 3'd5, 0);
        check(neg_sel == 4'd8, "R10 converter on", int'(neg_sel), 8);
        wr(2'b00, 1, 0, 0, 3'd6, 0);
        check(neg_sel == 4'd8, "R10 mux disabled", int'(neg_sel), 8);
        wr(2'b00, 1, 0, 1, 3'd3, 0);
        check(neg_sel == 4'd8, "R10 both off paths", int'(neg_sel), 8);

        cyc(4);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule